// File: doc/BRIEF.md
# Bank-Interleaved Dual-Access Data Array

This block is the data store of a set-associative cache. Each line is 32 bytes wide. The line is split into eight 4-byte words, and each word lives in its own bank. Every bank has a single port. Two pipes present requests in the same cycle. Each request carries a set, a way, a word offset, byte enables, a write flag and write data. When the two word offsets differ, both requests are served in that cycle, even when they fall in the same line. When the offsets are equal, both requests want the same bank. Pipe 0 keeps the bank and pipe 1 is held off for that cycle. Tag compare and coherence state are handled elsewhere.

Each pipe's request side is a valid/ready stream. Pipe 0 is always ready. Pipe 1 ready drops, combinationally, whenever pipe 0 presents a valid request to the same bank. A pipe 1 requester that sees ready low must hold its request unchanged until a cycle in which ready is high. A request is taken only in a cycle where valid and ready are both high.

The read response appears one cycle after the request is accepted. It consists of a valid pulse, a 32-bit word and a parity error flag. The response side has no back-pressure, so the consumer must take it in that cycle.

Every stored byte has its own odd-parity bit. Reset clears both the data and the parity bits. As a result, any word not written since reset reads back as zero with its parity error flag raised.

Top module: `ildata_store`

## Requirements
- R1: The word offset (3 bits, values 0..7) selects the bank directly. The eight words of one line (one set and way) are eight independent 32-bit locations. Byte lane b of a word is bits [8b+7:8b].
- R2: When the two valid requests carry different word offsets, p1_ready is high. Both requests take effect in that cycle, including when they target the same set and way.
- R3: When p0_valid is high and both pipes carry the same word offset, p1_ready is low in that cycle, whatever p1_valid is.
- R4: p0_ready is high in every cycle after reset.
- R5: An accepted read raises that pipe's rvalid exactly one cycle later, with the stored word on rdata. An accepted write, or no accepted request, leaves rvalid low in the next cycle.
- R6: A write updates only the byte lanes whose enable bit is set. The other lanes of that word keep their value and their parity state.
- R7: Each written byte stores odd parity. perr is high in a response cycle exactly when at least one of the four bytes of that word fails the odd-parity check, and perr is never high without rvalid.
- R8: After reset every byte reads as zero with failing parity. An unwritten word therefore reads 0 with perr high, and a partly written word keeps perr high until all four lanes have been written.
- R9: A pipe 1 request offered while p1_ready is low changes no storage and produces no response.
- R10: While and right after reset, both rvalid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the storage and the response state |
| p0_valid | input | 1 | Pipe 0 request valid |
| p0_ready | output | 1 | Pipe 0 request ready (always high) |
| p0_we | input | 1 | Pipe 0 write (1) or read (0) |
| p0_set | input | SET_W | Pipe 0 set index |
| p0_way | input | WAY_W | Pipe 0 way |
| p0_word | input | 3 | Pipe 0 word offset, which is the bank |
| p0_be | input | 4 | Pipe 0 byte enables |
| p0_wdata | input | 32 | Pipe 0 write data |
| p0_rvalid | output | 1 | Pipe 0 read response valid |
| p0_rdata | output | 32 | Pipe 0 read data |
| p0_perr | output | 1 | Pipe 0 parity error on the returned word |
| p1_valid | input | 1 | Pipe 1 request valid |
| p1_ready | output | 1 | Pipe 1 request ready (low on a bank conflict) |
| p1_we | input | 1 | Pipe 1 write (1) or read (0) |
| p1_set | input | SET_W | Pipe 1 set index |
| p1_way | input | WAY_W | Pipe 1 way |
| p1_word | input | 3 | Pipe 1 word offset, which is the bank |
| p1_be | input | 4 | Pipe 1 byte enables |
| p1_wdata | input | 32 | Pipe 1 write data |
| p1_rvalid | output | 1 | Pipe 1 read response valid |
| p1_rdata | output | 32 | Pipe 1 read data |
| p1_perr | output | 1 | Pipe 1 parity error on the returned word |

## Verification
The properties assume that every request input is at a known level in each clock after reset. They also assume that a pipe 1 request refused by low ready is either held or withdrawn, never half-changed, because the response-timing checks count only handshaken reads.

The stimulus drives both pipes at the falling edge, so the inputs are stable at each rising edge. When p1_ready is low, the bench holds the pipe 1 request across cycles. The random phase mixes reads and writes with partial byte enables over a small set range, so conflicts, same-line pairs and reads of untouched words all occur often.

// File: rtl/ildata_pkg.sv
package ildata_pkg;
  localparam int LANES     = 4;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = LANES * BYTE_W;
  localparam int NUM_BANKS = 8;
  localparam int BANK_W    = $clog2(NUM_BANKS);
endpackage

// File: rtl/ildata_bank.sv
module ildata_bank
  import ildata_pkg::*;
#(
  parameter int IDX_W = 5,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LANES-1:0]  be,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic [LANES-1:0]  rpar
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [LANES-1:0]  par_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i] <= '0;
        par_q[i] <= '0;
      end
      rdata <= '0;
      rpar  <= '0;
    end else if (en) begin
      if (we) begin
        for (int b = 0; b < LANES; b++) begin
          if (be[b]) begin
            mem_q[idx][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
            par_q[idx][b]                  <= ~(^wdata[b*BYTE_W +: BYTE_W]);
          end
        end
      end else begin
        rdata <= mem_q[idx];
        rpar  <= par_q[idx];
      end
    end
  end
endmodule

// File: rtl/ildata_arb.sv
module ildata_arb
  import ildata_pkg::*;
(
  input  logic                 p0_valid,
  input  logic [BANK_W-1:0]    p0_word,
  input  logic                 p1_valid,
  input  logic [BANK_W-1:0]    p1_word,
  output logic                 p1_ready,
  output logic                 p1_fire,
  output logic [NUM_BANKS-1:0] sel0,
  output logic [NUM_BANKS-1:0] sel1
);
  assign p1_ready = !(p0_valid && (p0_word == p1_word));
  assign p1_fire  = p1_valid && p1_ready;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_sel
    assign sel0[g] = p0_valid && (p0_word == BANK_W'(g));
    assign sel1[g] = p1_fire  && (p1_word == BANK_W'(g));
  end
endmodule

// File: rtl/ildata_parchk.sv
module ildata_parchk
  import ildata_pkg::*;
(
  input  logic [WORD_W-1:0] data,
  input  logic [LANES-1:0]  par,
  output logic              err
);
  logic [LANES-1:0] lane_bad;
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign lane_bad[b] = ~(^{data[b*BYTE_W +: BYTE_W], par[b]});
  end
  assign err = |lane_bad;
endmodule

// File: rtl/ildata_store.sv
module ildata_store
  import ildata_pkg::*;
#(
  parameter int SETS = 16,
  parameter int WAYS = 2,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p0_valid,
  output logic              p0_ready,
  input  logic              p0_we,
  input  logic [SET_W-1:0]  p0_set,
  input  logic [WAY_W-1:0]  p0_way,
  input  logic [2:0]        p0_word,
  input  logic [3:0]        p0_be,
  input  logic [31:0]       p0_wdata,
  output logic              p0_rvalid,
  output logic [31:0]       p0_rdata,
  output logic              p0_perr,
  input  logic              p1_valid,
  output logic              p1_ready,
  input  logic              p1_we,
  input  logic [SET_W-1:0]  p1_set,
  input  logic [WAY_W-1:0]  p1_way,
  input  logic [2:0]        p1_word,
  input  logic [3:0]        p1_be,
  input  logic [31:0]       p1_wdata,
  output logic              p1_rvalid,
  output logic [31:0]       p1_rdata,
  output logic              p1_perr
);
  localparam int IDX_W = SET_W + WAY_W;

  logic [NUM_BANKS-1:0] sel0, sel1;
  logic                 p1_fire;
  logic [IDX_W-1:0]     idx0, idx1;
  logic [WORD_W-1:0]    bk_rdata [NUM_BANKS];
  logic [LANES-1:0]     bk_rpar  [NUM_BANKS];
  logic                 rd0_q, rd1_q;
  logic [BANK_W-1:0]    bk0_q, bk1_q;
  logic                 err0, err1;

  assign idx0     = {p0_set, p0_way};
  assign idx1     = {p1_set, p1_way};
  assign p0_ready = 1'b1;

  ildata_arb u_arb (
    .p0_valid (p0_valid),
    .p0_word  (p0_word),
    .p1_valid (p1_valid),
    .p1_word  (p1_word),
    .p1_ready (p1_ready),
    .p1_fire  (p1_fire),
    .sel0     (sel0),
    .sel1     (sel1)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic              b_en, b_we;
    logic [IDX_W-1:0]  b_idx;
    logic [LANES-1:0]  b_be;
    logic [WORD_W-1:0] b_wd;

    assign b_en  = sel0[g] | sel1[g];
    assign b_we  = sel0[g] ? p0_we    : p1_we;
    assign b_idx = sel0[g] ? idx0     : idx1;
    assign b_be  = sel0[g] ? p0_be    : p1_be;
    assign b_wd  = sel0[g] ? p0_wdata : p1_wdata;

    ildata_bank #(.IDX_W(IDX_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (b_en),
      .we    (b_we),
      .idx   (b_idx),
      .be    (b_be),
      .wdata (b_wd),
      .rdata (bk_rdata[g]),
      .rpar  (bk_rpar[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd0_q <= 1'b0;
      rd1_q <= 1'b0;
      bk0_q <= '0;
      bk1_q <= '0;
    end else begin
      rd0_q <= p0_valid && !p0_we;
      rd1_q <= p1_fire && !p1_we;
      bk0_q <= p0_word;
      bk1_q <= p1_word;
    end
  end

  ildata_parchk u_chk0 (.data(bk_rdata[bk0_q]), .par(bk_rpar[bk0_q]), .err(err0));
  ildata_parchk u_chk1 (.data(bk_rdata[bk1_q]), .par(bk_rpar[bk1_q]), .err(err1));

  assign p0_rvalid = rd0_q;
  assign p0_rdata  = bk_rdata[bk0_q];
  assign p0_perr   = rd0_q && err0;
  assign p1_rvalid = rd1_q;
  assign p1_rdata  = bk_rdata[bk1_q];
  assign p1_perr   = rd1_q && err1;
endmodule

// File: rtl/ildata_store_chk.sv
module ildata_store_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       p0_valid,
  input logic       p0_ready,
  input logic       p0_we,
  input logic [2:0] p0_word,
  input logic       p0_rvalid,
  input logic       p0_perr,
  input logic       p1_valid,
  input logic       p1_ready,
  input logic       p1_we,
  input logic [2:0] p1_word,
  input logic       p1_rvalid,
  input logic       p1_perr
);
  // R4
  p_p0_always_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    p0_ready);

  // R3
  p_same_bank_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_valid && p0_word == p1_word) |-> !p1_ready);

  // R2
  p_split_bank_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!p0_valid || p0_word != p1_word) |-> p1_ready);

  // R5
  p_p0_read_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_valid && !p0_we) |=> p0_rvalid);
  p_p0_no_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(p0_valid && !p0_we) |=> !p0_rvalid);
  p_p1_read_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_valid && p1_ready && !p1_we) |=> p1_rvalid);

  // R9
  p_p1_refused_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(p1_valid && p1_ready && !p1_we) |=> !p1_rvalid);

  // R7
  p_perr_in_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_perr |-> p0_rvalid) and (p1_perr |-> p1_rvalid));
endmodule

bind ildata_store ildata_store_chk u_store_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .p0_valid  (p0_valid),
  .p0_ready  (p0_ready),
  .p0_we     (p0_we),
  .p0_word   (p0_word),
  .p0_rvalid (p0_rvalid),
  .p0_perr   (p0_perr),
  .p1_valid  (p1_valid),
  .p1_ready  (p1_ready),
  .p1_we     (p1_we),
  .p1_word   (p1_word),
  .p1_rvalid (p1_rvalid),
  .p1_perr   (p1_perr)
);

// File: tb/ildata_store_bench.sv
`timescale 1ns/1ps
module ildata_store_bench;
  localparam int SETS = 16;
  localparam int WAYS = 2;
  localparam int SET_W = 4;
  localparam int WAY_W = 1;
  localparam int NWORDS = SETS * WAYS * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic p0_valid, p0_ready, p0_we, p0_rvalid, p0_perr;
  logic [SET_W-1:0] p0_set;
  logic [WAY_W-1:0] p0_way;
  logic [2:0] p0_word;
  logic [3:0] p0_be;
  logic [31:0] p0_wdata, p0_rdata;
  logic p1_valid, p1_ready, p1_we, p1_rvalid, p1_perr;
  logic [SET_W-1:0] p1_set;
  logic [WAY_W-1:0] p1_way;
  logic [2:0] p1_word;
  logic [3:0] p1_be;
  logic [31:0] p1_wdata, p1_rdata;

  ildata_store #(.SETS(SETS), .WAYS(WAYS)) u_ildata_store (.*);

  // reference: bytes and a "never written" mark per byte
  logic [7:0] ref_byte [NWORDS*4];
  bit         ref_bad  [NWORDS*4];
  int tests = 0, fails = 0;
  bit done = 0;

  function automatic int waddr(input logic [SET_W-1:0] s, input logic [WAY_W-1:0] w,
                               input logic [2:0] wd);
    return ((int'(s) * WAYS + int'(w)) * 8 + int'(wd)) * 4;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    p0_valid = 0; p0_we = 0; p0_set = '0; p0_way = '0; p0_word = '0; p0_be = '0; p0_wdata = '0;
    p1_valid = 0; p1_we = 0; p1_set = '0; p1_way = '0; p1_word = '0; p1_be = '0; p1_wdata = '0;
  endtask

  // one clock: inputs already driven at the falling edge
  task automatic tick(input string req);
    bit e1rdy, f0, f1, ev0, ev1, ee0, ee1;
    logic [31:0] ed0, ed1;
    int a;
    #1;
    e1rdy = !(p0_valid && p0_word == p1_word);
    chk("R4", "p0_ready", 32'(p0_ready), 32'd1);
    chk(e1rdy ? "R2" : "R3", "p1_ready", 32'(p1_ready), 32'(e1rdy));
    f0 = p0_valid;
    f1 = p1_valid && e1rdy;
    ev0 = f0 && !p0_we; ev1 = f1 && !p1_we;
    ed0 = '0; ed1 = '0; ee0 = 0; ee1 = 0;
    a = waddr(p0_set, p0_way, p0_word);
    for (int b = 0; b < 4; b++) begin ed0[b*8 +: 8] = ref_byte[a+b]; ee0 |= ref_bad[a+b]; end
    a = waddr(p1_set, p1_way, p1_word);
    for (int b = 0; b < 4; b++) begin ed1[b*8 +: 8] = ref_byte[a+b]; ee1 |= ref_bad[a+b]; end
    if (f0 && p0_we) begin
      a = waddr(p0_set, p0_way, p0_word);
      for (int b = 0; b < 4; b++)
        if (p0_be[b]) begin ref_byte[a+b] = p0_wdata[b*8 +: 8]; ref_bad[a+b] = 0; end
    end
    if (f1 && p1_we) begin
      a = waddr(p1_set, p1_way, p1_word);
      for (int b = 0; b < 4; b++)
        if (p1_be[b]) begin ref_byte[a+b] = p1_wdata[b*8 +: 8]; ref_bad[a+b] = 0; end
    end
    @(posedge clk);
    @(negedge clk);
    chk(f1 || !p1_valid ? "R5" : "R9", "p1_rvalid", 32'(p1_rvalid), 32'(ev1));
    chk("R5", "p0_rvalid", 32'(p0_rvalid), 32'(ev0));
    if (ev0) begin
      chk(req, "p0_rdata", p0_rdata, ed0);
      chk("R7", "p0_perr", 32'(p0_perr), 32'(ee0));
    end
    if (ev1) begin
      chk(req, "p1_rdata", p1_rdata, ed1);
      chk("R7", "p1_perr", 32'(p1_perr), 32'(ee1));
    end
  endtask

  task automatic req0(input bit we, input int s, input int w, input int wd,
                      input logic [3:0] be, input logic [31:0] d);
    p0_valid = 1; p0_we = we; p0_set = SET_W'(s); p0_way = WAY_W'(w);
    p0_word = 3'(wd); p0_be = be; p0_wdata = d;
  endtask
  task automatic req1(input bit we, input int s, input int w, input int wd,
                      input logic [3:0] be, input logic [31:0] d);
    p1_valid = 1; p1_we = we; p1_set = SET_W'(s); p1_way = WAY_W'(w);
    p1_word = 3'(wd); p1_be = be; p1_wdata = d;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NWORDS*4; i++) begin ref_byte[i] = 8'h00; ref_bad[i] = 1; end
    idle();
    repeat (3) @(negedge clk);
    // R10: outputs during reset
    chk("R10", "p0_rvalid in reset", 32'(p0_rvalid), 32'd0);
    chk("R10", "p1_rvalid in reset", 32'(p1_rvalid), 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R10", "p0_rvalid after reset", 32'(p0_rvalid), 32'd0);
    chk("R10", "p1_rvalid after reset", 32'(p1_rvalid), 32'd0);

    // R8: unwritten words read zero with failing parity
    idle(); req0(0, 0, 0, 0, 4'h0, 0); req1(0, 0, 0, 1, 4'h0, 0); tick("R8");

    // R1/R2: fill a line two words per cycle, same line
    for (int w = 0; w < 4; w++) begin
      idle();
      req0(1, 3, 1, w, 4'hF, 32'hA0B0C0D0 + 32'(w));
      req1(1, 3, 1, w + 4, 4'hF, 32'h1F2E3D4C ^ 32'(w << 8));
      tick("R2");
    end
    // R1/R5: read the line back, each word independent
    for (int w = 0; w < 4; w++) begin
      idle(); req0(0, 3, 1, 7 - w, 4'h0, 0); req1(0, 3, 1, w, 4'h0, 0); tick("R1");
    end

    // R6: partial byte write, then read
    idle(); req0(1, 3, 1, 2, 4'b0101, 32'h11223344); tick("R6");
    idle(); req0(0, 3, 1, 2, 4'h0, 0); tick("R6");

    // R8: partially written word keeps parity failing
    idle(); req1(1, 5, 0, 0, 4'b0001, 32'h000000EE); tick("R8");
    idle(); req1(0, 5, 0, 0, 4'h0, 0); tick("R8");
    idle(); req0(1, 5, 0, 0, 4'b1110, 32'h7766550F); tick("R7");
    idle(); req0(0, 5, 0, 0, 4'h0, 0); tick("R7");

    // R3/R9: conflict, refused pipe 1 write leaves storage untouched
    idle(); req0(0, 3, 1, 3, 4'h0, 0); req1(1, 9, 0, 3, 4'hF, 32'hDEADBEEF); tick("R3");
    idle(); req1(0, 9, 0, 3, 4'h0, 0); tick("R9");
    // R3: ready low even without p1_valid
    idle(); req0(1, 2, 0, 6, 4'hF, 32'h0BADF00D); p1_word = 3'd6; tick("R3");

    // R2: write one word while reading its neighbour in the same line
    idle(); req0(1, 3, 1, 5, 4'hF, 32'hCAFE0005); req1(0, 3, 1, 6, 4'h0, 0); tick("R2");
    idle(); req1(0, 3, 1, 5, 4'h0, 0); tick("R2");

    // random phase, pipe 1 holds its request while refused
    idle();
    for (int n = 0; n < 4000; n++) begin
      bit hold;
      hold = p1_valid && !p1_ready;
      p0_valid = ($urandom % 4) != 0;
      p0_we = $urandom % 2; p0_set = SET_W'($urandom % 4); p0_way = WAY_W'($urandom);
      p0_word = 3'($urandom); p0_be = 4'($urandom); p0_wdata = $urandom;
      if (!hold) begin
        p1_valid = ($urandom % 4) != 0;
        p1_we = $urandom % 2; p1_set = SET_W'($urandom % 4); p1_way = WAY_W'($urandom);
        p1_word = 3'($urandom); p1_be = 4'($urandom); p1_wdata = $urandom;
      end
      tick("R1");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule